// File: doc/BRIEF.md
# Toggle-Rate Serial Link Codec

This block carries 16-bit words over a single wire between two parts of a chip, or two chips, that run on separate free-running clocks of the same nominal frequency. Every bit takes two periods of the sending clock. A one is sent by toggling the wire in both periods. A zero is sent by toggling it only at the start of the bit. Because information lives in the spacing of transitions and not in the wire level, the stream stays DC balanced. The receiver does not care which way round the wire is connected, and no recovered clock is needed.

The sending side accepts a word through a valid/ready handshake. It frames the word as a start bit of value one followed by the sixteen data bits, most significant first. Between words it keeps sending zeros, so the wire toggles every second cycle. The receiving side passes the wire through a two-flop synchronizer. It measures the gap between successive transitions as short (one cycle), long (two cycles) or out of range. It hunts for the two short gaps of a start bit, assembles the data bits and then raises a one-cycle strobe with the word. If a gap is out of range, or a short gap is followed by a long gap inside a bit, the receiver pulses a framing error and goes back to hunting.

Top module: `fm_link_codec`

## Requirements
- R1: While a reset is held, `line_out`, `tx_take`, `rx_word_vld` and `rx_frame_err` are all low.
- R2: With no word offered, `line_out` changes level every second `tx_clk` cycle and never on two cycles in a row.
- R3: `tx_take` is high for one cycle at the end of each bit period, and only when no word is in flight. After a word is accepted, `tx_take` next rises in the 34th cycle after the accepting edge.
- R4: After acceptance, the line carries a start bit of value one, then the 16 data bits, most significant first. Each bit spans two cycles. The line changes at the start of every bit, and changes again in the second cycle only for a one.
- R5: The receiver presents each frame as exactly one cycle of `rx_word_vld` with `rx_word` equal to the word sent.
- R6: Decoding gives the same words when `line_in` is the inverse of `line_out`.
- R7: During a frame, three cycles without a transition raise a one-cycle `rx_frame_err` and deliver no word. The next well-formed frame is received correctly.
- R8: During a frame, a one-cycle gap followed by a two-cycle gap inside one bit raises `rx_frame_err` and delivers no word.
- R9: While hunting, a line held at a constant level raises neither `rx_frame_err` nor `rx_word_vld`.
- R10: A word offered while the previous one is in flight goes out directly after it with no idle bit in between. Both words are received in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tx_clk | input | 1 | Sending-side clock |
| tx_rst | input | 1 | Synchronous active-high reset, sending side |
| tx_word | input | 16 | Word to send |
| tx_offer | input | 1 | Word on `tx_word` is valid |
| tx_take | output | 1 | Word accepted on this edge when `tx_offer` is high |
| line_out | output | 1 | Serial wire output |
| rx_clk | input | 1 | Receiving-side clock, free running |
| rx_rst | input | 1 | Synchronous active-high reset, receiving side |
| line_in | input | 1 | Serial wire input, either polarity |
| rx_word | output | 16 | Last received word |
| rx_word_vld | output | 1 | One-cycle strobe: `rx_word` is new |
| rx_frame_err | output | 1 | One-cycle strobe: a frame was abandoned |

## Verification
A wrong transmit state shows at the wire at once. A missed or extra toggle breaks the two-cycle idle rhythm or the per-bit pattern within one bit period. A wrong transmit bit counter moves the next rise of `tx_take` away from cycle 34. A wrong receive state shows as a wrong, missing or duplicated word, or as a spurious error strobe. This becomes visible at the end of the frame, about 34 cycles after the start bit, or within three cycles of a malformed gap.

// File: rtl/fm_link_pkg.sv
package fm_link_pkg;

    localparam int unsigned WORD_W_DEF = 16;

    // transition spacing counter: 1 = short, 2 = long, 3 = saturated/out of range
    localparam int unsigned SPAN_W = 2;
    localparam logic [SPAN_W-1:0] SPAN_SHORT = 2'd1;
    localparam logic [SPAN_W-1:0] SPAN_LONG  = 2'd2;
    localparam logic [SPAN_W-1:0] SPAN_CAP   = 2'd3;

    typedef enum logic [1:0] {
        GAP_NONE,
        GAP_SHORT,
        GAP_LONG,
        GAP_BAD
    } gap_e;

    typedef struct packed {
        logic edge_seen;
        logic level;
        gap_e gap;
    } gap_evt_t;

    typedef enum logic [1:0] {
        DEC_HUNT,
        DEC_START,
        DEC_DATA
    } dec_state_e;

    function automatic gap_e grade_gap(input logic [SPAN_W-1:0] span);
        gap_e g;
        if (span == SPAN_SHORT)     g = GAP_SHORT;
        else if (span == SPAN_LONG) g = GAP_LONG;
        else                        g = GAP_BAD;
        return g;
    endfunction

endpackage

// File: rtl/fm_tx_encoder.sv
module fm_tx_encoder
    import fm_link_pkg::*;
#(
    parameter int unsigned WORD_W = WORD_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] word_i,
    input  logic              offer_i,
    output logic              take_o,
    output logic              line_o
);
    localparam int unsigned LEFT_W = $clog2(WORD_W + 1);

    logic              second_q;   // 0: first cycle of bit, 1: second cycle
    logic              bit_q;      // bit currently on the wire
    logic [WORD_W-1:0] shift_q;
    logic [LEFT_W-1:0] left_q;     // data bits still to load
    logic              line_q;

    // accept only on the last cycle of a bit with nothing queued
    assign take_o = second_q && (left_q == '0);
    assign line_o = line_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            second_q <= 1'b0;
            bit_q    <= 1'b0;
            shift_q  <= '0;
            left_q   <= '0;
            line_q   <= 1'b0;
        end else begin
            second_q <= ~second_q;
            if (!second_q) begin
                // mid-bit edge only for a one
                if (bit_q) line_q <= ~line_q;
            end else begin
                // every bit boundary toggles
                line_q <= ~line_q;
                if (left_q != '0) begin
                    bit_q   <= shift_q[WORD_W-1];
                    shift_q <= {shift_q[WORD_W-2:0], 1'b0};
                    left_q  <= left_q - 1'b1;
                end else if (offer_i) begin
                    bit_q   <= 1'b1;           // start bit
                    shift_q <= word_i;
                    left_q  <= LEFT_W'(WORD_W);
                end else begin
                    bit_q   <= 1'b0;           // idle filler
                end
            end
        end
    end

endmodule

// File: rtl/fm_rx_gap_meter.sv
module fm_rx_gap_meter
    import fm_link_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     line_i,
    output gap_evt_t evt_o
);
    localparam int unsigned CHAIN = SYNC_STAGES + 1;

    logic [CHAIN-1:0]  chain_q;
    logic [SPAN_W-1:0] span_q;
    logic              edge_now;

    genvar gi;
    generate
        for (gi = 0; gi < CHAIN; gi++) begin : g_stage
            if (gi == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain_q[gi] <= 1'b0;
                    else     chain_q[gi] <= line_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain_q[gi] <= 1'b0;
                    else     chain_q[gi] <= chain_q[gi-1];
                end
            end
        end
    endgenerate

    assign edge_now = chain_q[CHAIN-1] ^ chain_q[CHAIN-2];

    // cycles since the previous transition, saturating
    always_ff @(posedge clk) begin
        if (rst) begin
            span_q <= SPAN_CAP;
        end else if (edge_now) begin
            span_q <= SPAN_SHORT;
        end else if (span_q != SPAN_CAP) begin
            span_q <= span_q + 1'b1;
        end
    end

    always_comb begin
        evt_o.edge_seen = edge_now;
        evt_o.level     = chain_q[CHAIN-2];
        if (edge_now)              evt_o.gap = grade_gap(span_q);
        else if (span_q == SPAN_CAP) evt_o.gap = GAP_BAD;
        else                       evt_o.gap = GAP_NONE;
    end

endmodule

// File: rtl/fm_rx_decoder.sv
module fm_rx_decoder
    import fm_link_pkg::*;
#(
    parameter int unsigned WORD_W = WORD_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  gap_evt_t          evt_i,
    output logic [WORD_W-1:0] word_o,
    output logic              word_vld_o,
    output logic              frame_err_o
);
    localparam int unsigned NBIT_W = $clog2(WORD_W);

    dec_state_e        st_q;
    logic [WORD_W-1:0] acc_q;
    logic [NBIT_W-1:0] nbit_q;
    logic              half_q;

    logic bit_done, bit_val, fail, half_d;

    // classify the current gap inside a data bit
    always_comb begin
        bit_done = 1'b0;
        bit_val  = 1'b0;
        fail     = 1'b0;
        half_d   = half_q;
        if (st_q == DEC_DATA) begin
            unique case (evt_i.gap)
                GAP_SHORT: begin
                    if (half_q) begin
                        bit_done = 1'b1;
                        bit_val  = 1'b1;
                        half_d   = 1'b0;
                    end else begin
                        half_d = 1'b1;
                    end
                end
                GAP_LONG: begin
                    if (half_q) fail = 1'b1;
                    else        bit_done = 1'b1;
                end
                GAP_BAD:  fail = 1'b1;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q        <= DEC_HUNT;
            acc_q       <= '0;
            nbit_q      <= '0;
            half_q      <= 1'b0;
            word_o      <= '0;
            word_vld_o  <= 1'b0;
            frame_err_o <= 1'b0;
        end else begin
            word_vld_o  <= 1'b0;
            frame_err_o <= 1'b0;
            unique case (st_q)
                DEC_HUNT: begin
                    if (evt_i.gap == GAP_SHORT) st_q <= DEC_START;
                end
                DEC_START: begin
                    if (evt_i.gap == GAP_SHORT) begin
                        st_q   <= DEC_DATA;
                        nbit_q <= '0;
                        half_q <= 1'b0;
                    end else if (evt_i.gap != GAP_NONE) begin
                        frame_err_o <= 1'b1;
                        st_q        <= DEC_HUNT;
                    end
                end
                DEC_DATA: begin
                    half_q <= half_d;
                    if (fail) begin
                        frame_err_o <= 1'b1;
                        half_q      <= 1'b0;
                        st_q        <= DEC_HUNT;
                    end else if (bit_done) begin
                        acc_q <= {acc_q[WORD_W-2:0], bit_val};
                        if (nbit_q == NBIT_W'(WORD_W - 1)) begin
                            word_o     <= {acc_q[WORD_W-2:0], bit_val};
                            word_vld_o <= 1'b1;
                            st_q       <= DEC_HUNT;
                        end else begin
                            nbit_q <= nbit_q + 1'b1;
                        end
                    end
                end
                default: st_q <= DEC_HUNT;
            endcase
        end
    end

endmodule

// File: rtl/fm_link_codec.sv
module fm_link_codec
    import fm_link_pkg::*;
#(
    parameter int unsigned WORD_W      = WORD_W_DEF,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              tx_clk,
    input  logic              tx_rst,
    input  logic [WORD_W-1:0] tx_word,
    input  logic              tx_offer,
    output logic              tx_take,
    output logic              line_out,
    input  logic              rx_clk,
    input  logic              rx_rst,
    input  logic              line_in,
    output logic [WORD_W-1:0] rx_word,
    output logic              rx_word_vld,
    output logic              rx_frame_err
);
    gap_evt_t gap_evt;

    fm_tx_encoder #(.WORD_W(WORD_W)) u_tx (
        .clk     (tx_clk),
        .rst     (tx_rst),
        .word_i  (tx_word),
        .offer_i (tx_offer),
        .take_o  (tx_take),
        .line_o  (line_out)
    );

    fm_rx_gap_meter #(.SYNC_STAGES(SYNC_STAGES)) u_meter (
        .clk    (rx_clk),
        .rst    (rx_rst),
        .line_i (line_in),
        .evt_o  (gap_evt)
    );

    fm_rx_decoder #(.WORD_W(WORD_W)) u_dec (
        .clk         (rx_clk),
        .rst         (rx_rst),
        .evt_i       (gap_evt),
        .word_o      (rx_word),
        .word_vld_o  (rx_word_vld),
        .frame_err_o (rx_frame_err)
    );

endmodule

// File: rtl/fm_link_checker.sv
module fm_link_checker #(
    parameter int unsigned WORD_W      = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input logic              tx_clk,
    input logic              tx_rst,
    input logic [WORD_W-1:0] tx_word,
    input logic              tx_offer,
    input logic              tx_take,
    input logic              line_out,
    input logic              rx_clk,
    input logic              rx_rst,
    input logic              line_in,
    input logic [WORD_W-1:0] rx_word,
    input logic              rx_word_vld,
    input logic              rx_frame_err
);
    logic       prev_line_q;
    logic [1:0] still_q;

    // count consecutive cycles with an unchanged wire level
    always_ff @(posedge tx_clk) begin
        if (tx_rst) begin
            prev_line_q <= 1'b1;
            still_q     <= '0;
        end else begin
            prev_line_q <= line_out;
            if (line_out == prev_line_q) begin
                if (still_q != 2'd3) still_q <= still_q + 1'b1;
            end else begin
                still_q <= '0;
            end
        end
    end

    // R1
    tx_reset_quiet_chk: assert property (@(posedge tx_clk)
        tx_rst |=> (!line_out && !tx_take));

    // R2
    line_keeps_moving_chk: assert property (@(posedge tx_clk) disable iff (tx_rst)
        still_q <= 2'd1);

    // R3
    take_drops_after_accept_chk: assert property (@(posedge tx_clk) disable iff (tx_rst)
        (tx_offer && tx_take) |=> !tx_take);

    // R3
    take_single_cycle_chk: assert property (@(posedge tx_clk) disable iff (tx_rst)
        tx_take |=> !tx_take);

    // R5
    word_strobe_pulse_chk: assert property (@(posedge rx_clk) disable iff (rx_rst)
        rx_word_vld |=> !rx_word_vld);

    // R7
    err_strobe_pulse_chk: assert property (@(posedge rx_clk) disable iff (rx_rst)
        rx_frame_err |=> !rx_frame_err);

    // R7
    err_excludes_word_chk: assert property (@(posedge rx_clk) disable iff (rx_rst)
        !(rx_frame_err && rx_word_vld));

endmodule

bind fm_link_codec fm_link_checker #(
    .WORD_W      (WORD_W),
    .SYNC_STAGES (SYNC_STAGES)
) u_fm_link_checker (.*);

// File: tb/test_fm_link_codec.sv
module test_fm_link_codec;

    localparam int CLK_PERIOD = 10;
    localparam int W = 16;

    // {invert_line, word}
    localparam logic [W:0] VECS [8] = '{
        {1'b0, 16'hA55A},
        {1'b0, 16'h0000},
        {1'b0, 16'hFFFF},
        {1'b0, 16'h8001},
        {1'b1, 16'h1234},
        {1'b1, 16'hFFFF},
        {1'b1, 16'h0000},
        {1'b1, 16'h7FFE}
    };

    logic         tx_clk = 1'b0, rx_clk = 1'b0;
    logic         tx_rst = 1'b1, rx_rst = 1'b1;
    logic [W-1:0] tx_word = '0;
    logic         tx_offer = 1'b0;
    logic         tx_take, line_out, line_in;
    logic [W-1:0] rx_word;
    logic         rx_word_vld, rx_frame_err;
    logic         invert = 1'b0, force_en = 1'b0, force_val = 1'b0;

    int checks = 0, fails = 0;
    int total_got = 0, total_err = 0;
    logic [W-1:0] got [64];

    always #(CLK_PERIOD/2) tx_clk = ~tx_clk;
    initial begin
        #3;
        forever #(CLK_PERIOD/2) rx_clk = ~rx_clk;
    end

    assign line_in = force_en ? force_val : (line_out ^ invert);

    fm_link_codec i_fm_link_codec (
        .tx_clk, .tx_rst, .tx_word, .tx_offer, .tx_take, .line_out,
        .rx_clk, .rx_rst, .line_in, .rx_word, .rx_word_vld, .rx_frame_err
    );

    always @(negedge rx_clk) begin
        if (!rx_rst) begin
            if (rx_word_vld) begin
                got[total_got % 64] = rx_word;
                total_got++;
            end
            if (rx_frame_err) total_err++;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic rx_restart();
        rx_rst = 1'b1;
        repeat (3) @(negedge rx_clk);
        rx_rst = 1'b0;
        repeat (10) @(negedge rx_clk);
    endtask

    // offer a word and return after the accepting edge
    task automatic tx_send(input logic [W-1:0] w, output logic prev);
        @(negedge tx_clk);
        tx_word  = w;
        tx_offer = 1'b1;
        for (int n = 0; n < 100 && !tx_take; n++) @(negedge tx_clk);
        prev = line_out;
        @(posedge tx_clk);
        #1 tx_offer = 1'b0;
    endtask

    task automatic wait_words(input int target);
        for (int n = 0; n < 400 && total_got < target; n++) @(negedge rx_clk);
    endtask

    task automatic fp(input logic t);
        force_val = force_val ^ t;
        @(negedge rx_clk);
    endtask

    task automatic fbit(input logic b);
        fp(1'b1);
        fp(b);
    endtask

    task automatic fword(input logic [W-1:0] w);
        fbit(1'b1);
        for (int i = W - 1; i >= 0; i--) fbit(w[i]);
        for (int i = 0; i < 3; i++) fbit(1'b0);
    endtask

    int base_got, base_err, changes, run;
    logic prev, cur;
    logic [16:0] frame;

    initial begin
        // R1 reset state
        repeat (4) @(negedge tx_clk);
        check(line_out == 1'b0, "R1 line_out", line_out, 0);
        check(tx_take == 1'b0, "R1 tx_take", tx_take, 0);
        check(rx_word_vld == 1'b0, "R1 rx_word_vld", rx_word_vld, 0);
        check(rx_frame_err == 1'b0, "R1 rx_frame_err", rx_frame_err, 0);
        tx_rst = 1'b0;
        rx_rst = 1'b0;

        // R2 idle rhythm
        @(negedge tx_clk);
        prev = line_out;
        changes = 0;
        run = 0;
        for (int i = 0; i < 12; i++) begin
            @(negedge tx_clk);
            if (line_out != prev) begin
                changes++;
                if (run == 0 && i > 0) run = 99;
                run = 0;
            end else run++;
            if (run > 1) run = 99;
            prev = line_out;
        end
        check(changes == 6 && run < 2, "R2 idle toggles", changes, 6);

        // table walk: R5 and R6
        for (int v = 0; v < 8; v++) begin
            invert = VECS[v][W];
            rx_restart();
            base_got = total_got;
            base_err = total_err;
            tx_send(VECS[v][W-1:0], prev);
            wait_words(base_got + 1);
            repeat (40) @(negedge rx_clk);
            check(total_got == base_got + 1,
                  VECS[v][W] ? "R6 word count inverted" : "R5 word count",
                  total_got - base_got, 1);
            check(got[base_got % 64] == VECS[v][W-1:0],
                  VECS[v][W] ? "R6 word inverted" : "R5 word",
                  got[base_got % 64], VECS[v][W-1:0]);
            check(total_err == base_err, "R5 no error", total_err - base_err, 0);
        end
        invert = 1'b0;
        rx_restart();

        // R3 and R4: wire pattern and ready timing for one word
        tx_send(16'hB2C5, prev);
        frame = {1'b1, 16'hB2C5};
        run = 0;
        for (int i = 0; i < 34; i++) begin
            @(negedge tx_clk);
            cur = line_out;
            if ((cur ^ prev) != ((i % 2 == 0) ? 1'b1 : frame[16 - i/2])) run++;
            if (i < 33 && tx_take) check(1'b0, "R3 take while busy", i + 1, 34);
            if (i == 33) check(tx_take == 1'b1, "R3 take in cycle 34", tx_take, 1);
            prev = cur;
        end
        check(run == 0, "R4 toggle pattern", run, 0);

        // R10 back-to-back
        repeat (80) @(negedge rx_clk);
        base_got = total_got;
        tx_send(16'h5A0F, prev);
        tx_send(16'hF0A5, prev);
        wait_words(base_got + 2);
        repeat (40) @(negedge rx_clk);
        check(total_got == base_got + 2, "R10 count", total_got - base_got, 2);
        check(got[base_got % 64] == 16'h5A0F, "R10 first", got[base_got % 64], 16'h5A0F);
        check(got[(base_got + 1) % 64] == 16'hF0A5, "R10 second",
              got[(base_got + 1) % 64], 16'hF0A5);

        // forced line from here on
        force_val = 1'b0;
        force_en  = 1'b1;
        rx_restart();
        for (int i = 0; i < 3; i++) fbit(1'b0);

        // R7 stall mid-frame
        base_got = total_got;
        base_err = total_err;
        fbit(1'b1); fbit(1'b1); fbit(1'b0);
        for (int i = 0; i < 6; i++) fp(1'b0);
        check(total_err == base_err + 1, "R7 stall error", total_err - base_err, 1);
        check(total_got == base_got, "R7 no word", total_got - base_got, 0);
        for (int i = 0; i < 3; i++) fbit(1'b0);
        base_err = total_err;
        fword(16'hC3A5);
        check(total_got == base_got + 1 && got[base_got % 64] == 16'hC3A5,
              "R7 recovery word", got[base_got % 64], 16'hC3A5);
        check(total_err == base_err, "R7 recovery clean", total_err - base_err, 0);

        // R8 short then long inside a bit
        base_got = total_got;
        base_err = total_err;
        fbit(1'b1);
        fp(1'b1); fp(1'b1); fp(1'b0); fp(1'b1);
        for (int i = 0; i < 4; i++) fbit(1'b0);
        check(total_err >= base_err + 1, "R8 split bit error", total_err - base_err, 1);
        check(total_got == base_got, "R8 no word", total_got - base_got, 0);

        // R9 constant line while hunting
        for (int i = 0; i < 3; i++) fbit(1'b0);
        base_got = total_got;
        base_err = total_err;
        for (int i = 0; i < 20; i++) fp(1'b0);
        check(total_err == base_err, "R9 no error", total_err - base_err, 0);
        check(total_got == base_got, "R9 no word", total_got - base_got, 0);
        for (int i = 0; i < 3; i++) fbit(1'b0);
        fword(16'h0F0F);
        check(total_got == base_got + 1 && got[base_got % 64] == 16'h0F0F,
              "R9 word after quiet", got[base_got % 64], 16'h0F0F);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        checks++;
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule